// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block gathers the four interrupt causes of a serial port channel (receive, error, transmit and modem) into a source register, filters them through a mask register and drives one registered interrupt line. The receive and transmit datapaths raise causes with single-cycle set pulses. Software clears causes by writing ones to the source or pending register, and it reconfigures filtering by rewriting the mask.

The transmit cause is also raised by level. While FIFO mode is on and the transmit FIFO holds no more entries than a trigger level, the transmit bit is set on every clock. The level is a 3-bit trigger field times a factor fixed by the channel number parameter. The block sits between the port's datapaths and the bus decoder, which supplies a register select, write strobe and write data and takes the read data back.

Top module: `uart_irq_combiner`

## Requirements
- R1: While rst_n is low and after its release, the source, mask and pending registers read 0 and irq_o is 0.
- R2: A set pulse on rx_set_i, err_set_i, tx_set_i or modem_set_i sets source bit 0, 1, 2 or 3 respectively, which is visible at the clock edge that samples the pulse.
- R3: The pending register always equals source AND NOT mask.
- R4: irq_o is high exactly when the pending register is non-zero, and it changes at the same edge as the pending register.
- R5: A write with wr_sel_i = 1 (pending) clears each bit written as 1 in both the source and pending registers and leaves the other bits unchanged.
- R6: A write with wr_sel_i = 0 (source) clears only the source bits written as 1 and does not change the mask.
- R7: A write with wr_sel_i = 2 (mask) replaces the whole mask, and pending and irq_o take the new mask into account at that same edge.
- R8: With fifo_en_i high, source bit 2 is set at each edge where tx_count_i is at or below trig_i times a factor of 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R9: With fifo_en_i low, tx_count_i and trig_i have no effect on the source register.
- R10: When a set pulse and a software clear target the same source bit in the same cycle, the bit ends up set.
- R11: wr_sel_i = 3 selects no register: a write with it changes nothing, and a read with rd_sel_i = 3 returns 0. rd_sel_i uses the same codes as wr_sel_i (0 source, 1 pending, 2 mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_set_i | input | 1 | Receive cause set pulse |
| err_set_i | input | 1 | Error cause set pulse |
| tx_set_i | input | 1 | Transmit cause set pulse (holding write completed) |
| modem_set_i | input | 1 | Modem cause set pulse |
| fifo_en_i | input | 1 | FIFO mode enabled |
| trig_i | input | TRIG_W | Transmit trigger field |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 source, 1 pending, 2 mask, 3 none |
| wr_data_i | input | 4 | Write data |
| rd_sel_i | input | 2 | Read target, same codes as wr_sel_i |
| rd_data_o | output | 4 | Read data of the selected register |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A hardware set of a cause and a software clear of the same cause can land in the same cycle, both through the source-register write and through the pending-register write. The bench provokes this by holding a set pulse high during the clearing write, and also by letting the transmit level trigger stay active across a clear. It judges the result by reading the source register back on the next cycle and expecting the contested bit set while the other cleared bits stay clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC      = 4;
  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Scaling of the transmit trigger field per channel number
  function automatic int unsigned trig_mult(input int unsigned chan);
    case (chan)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_tx_level.sv
module uart_irq_tx_level #(
  parameter int unsigned CHAN   = 1,
  parameter int          CNT_W  = 8,
  parameter int          TRIG_W = 3
) (
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              tx_req_o
);
  import uart_irq_pkg::*;

  localparam int unsigned MULT  = trig_mult(CHAN);
  localparam int          LVL_W = TRIG_W + 6;
  localparam int          CMP_W = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;

  logic [CMP_W-1:0] level_w;
  logic [CMP_W-1:0] count_w;

  always_comb begin
    level_w  = CMP_W'(trig_i) * CMP_W'(MULT);
    count_w  = CMP_W'(count_i);
    tx_req_o = fifo_en_i && (count_w <= level_w);
  end

endmodule

// File: rtl/uart_irq_src_bank.sv
module uart_irq_src_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] src_nxt_o,
  output logic [NSRC-1:0] src_q_o
);

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    logic bit_q;
    logic en_w;
    logic d_w;

    // set has priority over clear
    always_comb begin
      en_w = set_i[b] | clr_i[b];
      d_w  = set_i[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (en_w) begin
        bit_q <= d_w;
      end
    end

    assign src_nxt_o[b] = en_w ? d_w : bit_q;
    assign src_q_o[b]   = bit_q;
  end

endmodule

// File: rtl/uart_irq_pend_unit.sv
module uart_irq_pend_unit #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_nxt_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] mask_wd_i,
  output logic [NSRC-1:0] mask_q_o,
  output logic [NSRC-1:0] pend_q_o,
  output logic            irq_q_o
);

  logic [NSRC-1:0] mask_nxt;
  logic [NSRC-1:0] pend_nxt;
  logic            irq_nxt;

  always_comb begin
    mask_nxt = mask_we_i ? mask_wd_i : mask_q_o;
    pend_nxt = src_nxt_i & ~mask_nxt;
    irq_nxt  = |pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q_o <= '0;
    end else if (mask_we_i) begin
      mask_q_o <= mask_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q_o <= '0;
      irq_q_o  <= 1'b0;
    end else begin
      pend_q_o <= pend_nxt;
      irq_q_o  <= irq_nxt;
    end
  end

endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner #(
  parameter int unsigned CHAN   = 1,
  parameter int          CNT_W  = 8,
  parameter int          TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_set_i,
  input  logic              err_set_i,
  input  logic              tx_set_i,
  input  logic              modem_set_i,
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [3:0]        wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [3:0]        rd_data_o,
  output logic              irq_o
);
  import uart_irq_pkg::*;

  logic            tx_req;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] src_nxt;
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend_q;
  logic            mask_we;
  reg_sel_e        wsel;
  reg_sel_e        rsel;

  uart_irq_tx_level #(
    .CHAN   (CHAN),
    .CNT_W  (CNT_W),
    .TRIG_W (TRIG_W)
  ) tx_level_i (
    .fifo_en_i (fifo_en_i),
    .trig_i    (trig_i),
    .count_i   (tx_count_i),
    .tx_req_o  (tx_req)
  );

  always_comb begin
    wsel                = reg_sel_e'(wr_sel_i);
    rsel                = reg_sel_e'(rd_sel_i);
    set_vec             = '0;
    set_vec[SRC_RX]     = rx_set_i;
    set_vec[SRC_ERR]    = err_set_i;
    set_vec[SRC_TX]     = tx_set_i | tx_req;
    set_vec[SRC_MODEM]  = modem_set_i;
    clr_vec             = '0;
    if (wr_en_i && (wsel == SEL_SRC || wsel == SEL_PEND)) begin
      clr_vec = wr_data_i;
    end
    mask_we = wr_en_i && (wsel == SEL_MASK);
  end

  uart_irq_src_bank #(
    .NSRC (NSRC)
  ) src_bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .src_nxt_o (src_nxt),
    .src_q_o   (src_q)
  );

  uart_irq_pend_unit #(
    .NSRC (NSRC)
  ) pend_unit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_nxt_i (src_nxt),
    .mask_we_i (mask_we),
    .mask_wd_i (wr_data_i),
    .mask_q_o  (mask_q),
    .pend_q_o  (pend_q),
    .irq_q_o   (irq_o)
  );

  always_comb begin
    case (rsel)
      SEL_SRC:  rd_data_o = src_q;
      SEL_PEND: rd_data_o = pend_q;
      SEL_MASK: rd_data_o = mask_q;
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_set_i,
  input logic       err_set_i,
  input logic       modem_set_i,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [3:0] wr_data_i,
  input logic [3:0] src_q,
  input logic [3:0] mask_q,
  input logic [3:0] pend_q,
  input logic       irq_o
);
  import uart_irq_pkg::*;

  // R3
  pend_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == (src_q & ~mask_q));

  // R4
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_q != 4'b0000));

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set_i |=> src_q[SRC_RX]);

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_MASK) |=> mask_q == $past(wr_data_i));

  // R6
  src_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_SRC && wr_data_i[SRC_MODEM] && !modem_set_i)
      |=> !src_q[SRC_MODEM]);

  // R5
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_PEND && wr_data_i[SRC_ERR] && !err_set_i)
      |=> (!src_q[SRC_ERR] && !pend_q[SRC_ERR]));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_SRC && wr_data_i[SRC_RX] && rx_set_i)
      |=> src_q[SRC_RX]);

endmodule

bind uart_irq_combiner uart_irq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_set_i    (rx_set_i),
  .err_set_i   (err_set_i),
  .modem_set_i (modem_set_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .src_q       (src_q),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .irq_o       (irq_o)
);

// File: tb/uart_irq_combiner_tb.sv
module uart_irq_combiner_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int unsigned TB_CHAN    = 1;
  localparam int          CNT_W      = 8;
  localparam int          TRIG_W     = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rx_set, err_set, tx_set, modem_set;
  logic              fifo_en;
  logic [TRIG_W-1:0] trig;
  logic [CNT_W-1:0]  tx_count;
  logic              wr_en;
  logic [1:0]        wr_sel;
  logic [3:0]        wr_data;
  logic [1:0]        rd_sel;
  logic [3:0]        rd_data;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_combiner #(
    .CHAN   (TB_CHAN),
    .CNT_W  (CNT_W),
    .TRIG_W (TRIG_W)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_set_i    (rx_set),
    .err_set_i   (err_set),
    .tx_set_i    (tx_set),
    .modem_set_i (modem_set),
    .fifo_en_i   (fifo_en),
    .trig_i      (trig),
    .tx_count_i  (tx_count),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .rd_sel_i    (rd_sel),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sel, output logic [3:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] s);
    {modem_set, tx_set, err_set, rx_set} = s;
    tick();
    {modem_set, tx_set, err_set, rx_set} = 4'b0000;
  endtask

  function automatic int exp_mult(input int unsigned ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    rst_n = 1'b0;
    {rx_set, err_set, tx_set, modem_set} = 4'b0000;
    fifo_en = 1'b0; trig = '0; tx_count = '0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 4'h0; rd_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(2'd0, v); check("R1 src in reset", v, 0);
    rd(2'd1, v); check("R1 pend in reset", v, 0);
    rd(2'd2, v); check("R1 mask in reset", v, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick();
    rd(2'd0, v); check("R1 src after reset", v, 0);
    check("R1 irq after reset", irq, 0);

    // R2 R3 R4: exhaustive source x mask sweep
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        wr(2'd2, 4'(m));
        pulse(4'(s));
        rd(2'd0, v); check("R2 source bits", v, s);
        rd(2'd1, v); check("R3 pending", v, s & ~m & 15);
        rd(2'd2, v); check("R7 mask value", v, m);
        check("R4 irq", irq, ((s & ~m & 15) != 0) ? 1 : 0);
        wr(2'd0, 4'hF);
      end
    end

    // R7: mask rewrite re-evaluates at once
    wr(2'd2, 4'hF);
    pulse(4'b1011);
    check("R7 irq masked", irq, 0);
    wr(2'd2, 4'b0010);
    rd(2'd1, v); check("R7 pending after unmask", v, 4'b1001);
    check("R7 irq after unmask", irq, 1);
    wr(2'd2, 4'hF);
    check("R7 irq after full mask", irq, 0);
    wr(2'd2, 4'h0);
    wr(2'd0, 4'hF);

    // R5: pending write clears both
    pulse(4'hF);
    wr(2'd1, 4'b0101);
    rd(2'd0, v); check("R5 source after pend clear", v, 4'b1010);
    rd(2'd1, v); check("R5 pending after pend clear", v, 4'b1010);
    check("R5 irq still high", irq, 1);
    wr(2'd1, 4'b1010);
    check("R5 irq dropped", irq, 0);

    // R6: source write clears only written ones, mask kept
    wr(2'd2, 4'b0100);
    pulse(4'hF);
    wr(2'd0, 4'b0010);
    rd(2'd0, v); check("R6 source after clear", v, 4'b1101);
    rd(2'd2, v); check("R6 mask unchanged", v, 4'b0100);
    rd(2'd1, v); check("R6 pending", v, 4'b1001);
    wr(2'd0, 4'hF);
    wr(2'd2, 4'h0);

    // R10: set wins over clear in the same cycle
    rx_set = 1'b1;
    wr(2'd0, 4'hF);
    rx_set = 1'b0;
    rd(2'd0, v); check("R10 rx set beats source clear", v, 4'b0001);
    pulse(4'b0010);
    err_set = 1'b1;
    wr(2'd1, 4'b0011);
    err_set = 1'b0;
    rd(2'd0, v); check("R10 err set beats pending clear", v, 4'b0010);
    fifo_en = 1'b1; trig = 3'd1; tx_count = 8'd0;
    wr(2'd0, 4'hF);
    rd(2'd0, v); check("R10 level trigger beats clear", v, 4'b0100);
    fifo_en = 1'b0;
    wr(2'd0, 4'hF);

    // R11: select 3 writes nothing, reads zero
    wr(2'd2, 4'b1000);
    pulse(4'b0110);
    wr(2'd3, 4'hF);
    rd(2'd0, v); check("R11 source unchanged", v, 4'b0110);
    rd(2'd2, v); check("R11 mask unchanged", v, 4'b1000);
    rd(2'd3, v); check("R11 read none", v, 0);
    wr(2'd0, 4'hF);
    wr(2'd2, 4'h0);

    // R9: level trigger inert with FIFO mode off
    fifo_en = 1'b0; trig = 3'd7; tx_count = 8'd0;
    tick(); tick();
    rd(2'd0, v); check("R9 no tx source when fifo off", v, 0);
    check("R9 irq low when fifo off", irq, 0);

    // R8: sweep trigger field and count
    for (int t = 0; t < 8; t++) begin
      for (int c = 0; c < 256; c++) begin
        fifo_en = 1'b0;
        wr(2'd0, 4'hF);
        fifo_en = 1'b1; trig = 3'(t); tx_count = 8'(c);
        tick();
        fifo_en = 1'b0;
        rd(2'd0, v);
        check("R8 tx level source", v, (c <= t * exp_mult(TB_CHAN)) ? 4 : 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule